// File: doc/BRIEF.md
# Descriptor Mailbox Register Block

This block is a small register file on a 32-bit APB slave port inside a 4 KiB address window. Software uses it to post outbound descriptors and to take a completion-style interrupt. It holds five word registers: a base address, two outbound descriptor words, a control word and an interrupt status word. It drives one level interrupt line.

Two writes have side effects. Writing the second descriptor word with its trigger bit (bit 29) set raises status bit 16. Writing control touches only bit 31 and a two-bit field at 17:16, and that field copies a single written bit into both positions. Status bits are cleared by writing ones. Any access to an offset that is not one of the five registers completes with an error response, reads as zero and changes nothing. The bus takes no wait states. The interrupt output is a registered OR of the status word.

Top module: `desc_mailbox_regs`

## Requirements
- R1: After reset every register reads 0x00000000, irq_o is low and pslverr is low.
- R2: The base register (offset 0x000) and descriptor A (offset 0x028) store all 32 written bits and read them back unchanged.
- R3: A write to descriptor B (offset 0x02C) stores all 32 bits. When written bit 29 is 1, the same write sets bit 16 of status (offset 0x050).
- R4: A write to control (offset 0x04C) sets control bit 31 to written bit 31.
- R5: On a control write, control bits 17 and 16 both take the value of written bit 16, and written bit 17 has no effect. All other control bits keep their value, which is 0 from reset.
- R6: A write to status clears each status bit whose written bit is 1 and leaves every other status bit unchanged.
- R7: irq_o is high exactly in the cycles that follow a cycle in which status holds a nonzero value. It rises one clock after the write that sets status and falls one clock after the write that clears it.
- R8: A read of an unmapped or non-word-aligned offset returns 0, and pslverr is high in that access phase only.
- R9: A write to an unmapped offset raises pslverr in its access phase and changes no register.
- R10: pready is always high, so every transfer completes in its first access cycle.
- R11: A descriptor B write with bit 29 clear leaves status unchanged, including any bit already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Error response for an unmapped offset |
| irq_o | output | 1 | Level interrupt, registered OR of status |

## Verification
The assertions assume the master follows the APB protocol. penable is high only in the second cycle of a selected transfer, and paddr, pwrite and pwdata stay stable across setup and access, so each write takes effect in exactly one cycle. The stimulus comes from one task that always drives a setup cycle and then an access cycle, and returns the bus to idle between transfers. It applies reset only while the bus is idle, and afterwards it waits for the internal reset synchronizer to release before it starts the next transfer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WIN_AW = 12;
  localparam int REG_W  = 32;
  localparam int N_REG  = 5;

  localparam int IDX_BASE = 0;
  localparam int IDX_DA   = 1;
  localparam int IDX_DB   = 2;
  localparam int IDX_CTRL = 3;
  localparam int IDX_STAT = 4;

  localparam logic [WIN_AW-1:0] REG_OFF [N_REG] = '{
    12'h000, 12'h028, 12'h02C, 12'h04C, 12'h050
  };

  typedef logic [N_REG-1:0] sel_t;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic [WIN_AW-1:0] addr,
  output sel_t              sel,
  output logic              hit
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (addr == REG_OFF[i]) sel[i] = 1'b1;
    end
    hit = |sel;
  end
endmodule

// File: rtl/mbx_regbank.sv
module mbx_regbank
  import mbx_pkg::*;
#(
  parameter int TRIG_BIT = 29,
  parameter int FLAG_BIT = 16,
  parameter int LOCK_BIT = 31,
  parameter int PAIR_LO  = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  sel_t  sel,
  input  word_t wdata,
  output word_t base_q,
  output word_t da_q,
  output word_t db_q,
  output word_t ctrl_q,
  output word_t stat_q
);
  word_t base_d, da_d, db_d, ctrl_d, stat_d;

  always_comb begin
    base_d = base_q;
    da_d   = da_q;
    db_d   = db_q;
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    if (sel[IDX_BASE]) base_d = wdata;
    if (sel[IDX_DA])   da_d   = wdata;
    if (sel[IDX_DB]) begin
      db_d = wdata;
      if (wdata[TRIG_BIT]) stat_d[FLAG_BIT] = 1'b1;
    end
    if (sel[IDX_CTRL]) begin
      ctrl_d[LOCK_BIT]             = wdata[LOCK_BIT];
      ctrl_d[PAIR_LO+1:PAIR_LO]    = {2{wdata[PAIR_LO]}};
    end
    if (sel[IDX_STAT]) stat_d = stat_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      da_q   <= '0;
      db_q   <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else if (wr_en) begin
      base_q <= base_d;
      da_q   <= da_d;
      db_q   <= db_d;
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t stat,
  output logic  irq
);
  logic irq_d;

  always_comb irq_d = |stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/desc_mailbox_regs.sv
module desc_mailbox_regs
  import mbx_pkg::*;
#(
  parameter int TRIG_BIT = 29,
  parameter int FLAG_BIT = 16,
  parameter int LOCK_BIT = 31,
  parameter int PAIR_LO  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [WIN_AW-1:0] paddr,
  input  logic [REG_W-1:0]  pwdata,
  output logic [REG_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o
);
  logic  rst_n_sync;
  logic  access, wr_en, hit;
  sel_t  sel_raw, sel_wr;
  word_t base_q, da_q, db_q, ctrl_q, stat_q;
  word_t rd_vec [N_REG];

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  mbx_decode u_dec (.addr(paddr), .sel(sel_raw), .hit(hit));

  always_comb begin
    access = psel & penable;
    wr_en  = access & pwrite & hit;
    sel_wr = wr_en ? sel_raw : '0;
  end

  mbx_regbank #(
    .TRIG_BIT(TRIG_BIT), .FLAG_BIT(FLAG_BIT),
    .LOCK_BIT(LOCK_BIT), .PAIR_LO(PAIR_LO)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .sel(sel_wr), .wdata(pwdata),
    .base_q(base_q), .da_q(da_q), .db_q(db_q), .ctrl_q(ctrl_q), .stat_q(stat_q)
  );

  mbx_irq u_irq (.clk(clk), .rst_n(rst_n_sync), .stat(stat_q), .irq(irq_o));

  always_comb begin
    rd_vec[IDX_BASE] = base_q;
    rd_vec[IDX_DA]   = da_q;
    rd_vec[IDX_DB]   = db_q;
    rd_vec[IDX_CTRL] = ctrl_q;
    rd_vec[IDX_STAT] = stat_q;
    prdata = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (access && !pwrite && sel_raw[i]) prdata = prdata | rd_vec[i];
    end
  end

  assign pready  = 1'b1;
  assign pslverr = access & ~hit;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [WIN_AW-1:0] paddr,
  input logic [REG_W-1:0]  pwdata,
  input logic [REG_W-1:0]  prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              irq_o,
  input logic [REG_W-1:0]  base_q,
  input logic [REG_W-1:0]  da_q,
  input logic [REG_W-1:0]  db_q,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  stat_q
);
  logic acc_wr, acc_rd, mapped;
  always_comb begin
    acc_wr = psel && penable && pwrite;
    acc_rd = psel && penable && !pwrite;
    mapped = (paddr == 12'h000) || (paddr == 12'h028) || (paddr == 12'h02C) ||
             (paddr == 12'h04C) || (paddr == 12'h050);
  end

  p_db_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr == 12'h02C && pwdata[29]) |=> stat_q[16]);

  p_ctrl_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr == 12'h04C) |=> (ctrl_q[31] == $past(pwdata[31])));

  p_ctrl_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr == 12'h04C) |=> (ctrl_q[17:16] == {2{$past(pwdata[16])}}));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr == 12'h050) |=> ((stat_q & $past(pwdata)) == '0));

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=> irq_o);

  p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |=> !irq_o);

  p_bad_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !mapped) |-> (pslverr && prdata == '0));

  p_err_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable));

  p_bad_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !mapped) |=> ($stable(base_q) && $stable(da_q) && $stable(db_q) &&
                              $stable(ctrl_q) && $stable(stat_q)));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) pready);

  p_db_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr == 12'h02C && !pwdata[29]) |=> $stable(stat_q));
endmodule

bind desc_mailbox_regs mbx_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
  .pslverr(pslverr), .irq_o(irq_o), .base_q(base_q), .da_q(da_q), .db_q(db_q),
  .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/desc_mailbox_regs_tb_top.sv
`timescale 1ns/1ps
module desc_mailbox_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr, irq_o;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  desc_mailbox_regs dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b1, 12'h000, 32'hA5A5_1234, 32'h0, 1'b0},          // R2
    '{1'b0, 12'h000, 32'h0, 32'hA5A5_1234, 1'b0},          // R2
    '{1'b1, 12'h028, 32'hFFFF_FFFF, 32'h0, 1'b0},          // R2
    '{1'b0, 12'h028, 32'h0, 32'hFFFF_FFFF, 1'b0},          // R2
    '{1'b1, 12'h02C, 32'h1000_0001, 32'h0, 1'b0},          // R3
    '{1'b0, 12'h02C, 32'h0, 32'h1000_0001, 1'b0},          // R3
    '{1'b0, 12'h050, 32'h0, 32'h0000_0000, 1'b0},          // R11
    '{1'b1, 12'h04C, 32'hFFFF_FFFF, 32'h0, 1'b0},          // R4 R5
    '{1'b0, 12'h04C, 32'h0, 32'h8003_0000, 1'b0},          // R4 R5
    '{1'b1, 12'h04C, 32'h0002_0000, 32'h0, 1'b0},          // R5
    '{1'b0, 12'h04C, 32'h0, 32'h0000_0000, 1'b0},          // R5
    '{1'b1, 12'h04C, 32'h0001_0000, 32'h0, 1'b0},          // R5
    '{1'b0, 12'h04C, 32'h0, 32'h0003_0000, 1'b0},          // R5
    '{1'b0, 12'h100, 32'h0, 32'h0, 1'b1},                  // R8
    '{1'b1, 12'h104, 32'hFFFF_FFFF, 32'h0, 1'b1},          // R9
    '{1'b0, 12'h02A, 32'h0, 32'h0, 1'b1},                  // R8
    '{1'b0, 12'h000, 32'h0, 32'hA5A5_1234, 1'b0}           // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er, output logic rdy);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #0.5;
    rd = prdata; er = pslverr; rdy = pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic er, rdy;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 pslverr idle", {31'b0, pslverr}, 32'h0);
    foreach (mbx_pkg::REG_OFF[i]) begin
      apb(1'b0, mbx_pkg::REG_OFF[i], 32'h0, rd, er, rdy);
      check("R1 reset value", rd, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      apb(VT[i].wr, VT[i].addr, VT[i].data, rd, er, rdy);
      check("R10 pready", {31'b0, rdy}, 32'h1);
      check(VT[i].err ? "R8/R9 pslverr" : "R8 pslverr low", {31'b0, er}, {31'b0, VT[i].err});
      if (!VT[i].wr) check(VT[i].err ? "R8 bad read data" : "R2-5 readback", rd, VT[i].exp);
    end

    // R3 and R7: trigger sets status, irq one clock later
    apb(1'b1, 12'h02C, 32'h2000_0000, rd, er, rdy);
    check("R7 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7 irq rise", {31'b0, irq_o}, 32'h1);
    apb(1'b0, 12'h050, 32'h0, rd, er, rdy);
    check("R3 status flag", rd, 32'h0001_0000);
    // R11: write without trigger keeps status
    apb(1'b1, 12'h02C, 32'h0, rd, er, rdy);
    apb(1'b0, 12'h050, 32'h0, rd, er, rdy);
    check("R11 status kept", rd, 32'h0001_0000);
    // R9: unmapped write keeps status
    apb(1'b1, 12'h054, 32'hFFFF_FFFF, rd, er, rdy);
    check("R9 pslverr write", {31'b0, er}, 32'h1);
    apb(1'b0, 12'h050, 32'h0, rd, er, rdy);
    check("R9 status untouched", rd, 32'h0001_0000);
    // R6: zeros in written data leave bits
    apb(1'b1, 12'h050, 32'hFFFE_FFFF, rd, er, rdy);
    apb(1'b0, 12'h050, 32'h0, rd, er, rdy);
    check("R6 partial clear", rd, 32'h0001_0000);
    check("R7 irq held", {31'b0, irq_o}, 32'h1);
    apb(1'b1, 12'h050, 32'h0001_0000, rd, er, rdy);
    check("R7 irq one more cycle", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R7 irq fall", {31'b0, irq_o}, 32'h0);
    apb(1'b0, 12'h050, 32'h0, rd, er, rdy);
    check("R6 cleared", rd, 32'h0);

    // R1: reset mid-run restores zero
    apb(1'b1, 12'h02C, 32'h2000_0000, rd, er, rdy);
    apb(1'b1, 12'h04C, 32'h8001_0000, rd, er, rdy);
    do_reset();
    check("R1 irq after rerun reset", {31'b0, irq_o}, 32'h0);
    apb(1'b0, 12'h04C, 32'h0, rd, er, rdy);
    check("R1 ctrl reset", rd, 32'h0);
    apb(1'b0, 12'h02C, 32'h0, rd, er, rdy);
    check("R1 descB reset", rd, 32'h0);
    apb(1'b0, 12'h050, 32'h0, rd, er, rdy);
    check("R1 status reset", rd, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule